// File: doc/BRIEF.md
# Soft-Decision Viterbi Decoder, K=7 Rate 1/2

This block recovers the information bits of a rate 1/2 convolutional code with constraint length 7 (64 trellis states). Each input symbol is a pair of 4-bit soft values: the I value belongs to the 171 (octal) generator branch and the Q value to the 133 (octal) branch. Each value carries its own erasure flag, so an upstream depuncturer can mark the positions it filled in. The decoder returns one hard decision per accepted pair.

Processing is sequential and has three stages. First, one accepted symbol updates all 64 path metrics in parallel and stores a 64-bit decision word in a circular survivor memory of 144 entries. Second, the state with the smallest metric is chosen. Third, a traceback walks 144 steps back through the stored decisions and emits the bit that belongs to the symbol 144 positions earlier. While this work is in progress, `in_ready` is held low. An optional differential stage XORs each decoded bit with the one before it.

Path metrics are unsigned and are kept in range by subtracting a fixed amount from every state at once. The decoded stream is therefore identical to that of a decoder with unbounded metrics.

Top module: `viterbi_k7_decoder`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. State 0 starts with path metric 0 and every other state starts with 127, so decoding begins from the all-zero state.
- R2: A symbol is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in the cycle after that edge and stays 0 until the symbol's processing ends. A symbol held on the inputs while `in_ready` is 0 is taken exactly once.
- R3: The state is the last six input bits, newest in bit 5. The output pair for input bit u from state p is the parity of the 7-bit window {u, p} ANDed with 171 octal (I branch) and with 133 octal (Q branch). Window bit 6 is the newest bit. A noiseless encoding of a bit stream started from state 0, with each coded bit sent as soft value 15 (bit 1) or 0 (bit 0), decodes back to the original bits.
- R4: A soft value is unsigned 0..15. 0 means a confident 0 and 15 means a confident 1. Its branch cost is the value itself against an expected 0 and 15 minus the value against an expected 1. An erased value costs 0 against both.
- R5: For each next state, the decoder keeps the predecessor with the smaller accumulated metric and takes the even-numbered predecessor on a tie. Traceback starts from the state with the smallest metric and takes the lowest state number on a tie.
- R6: No stored path metric ever has its top bit set. When the smallest stored metric is at least 128 as a symbol is taken, 128 is subtracted from every new metric. The decoded stream equals that of a decoder with unbounded integer metrics.
- R7: The first 144 symbols produce no output. For symbol n ≥ 144, `out_valid` pulses for one cycle, 145 clock edges after the accepting edge, and carries the decision for symbol n-144.
- R8: With `diff_en` at 1, `out_bit` is the decoded bit XOR the previously decoded bit. The previous bit is tracked whatever the setting of `diff_en` and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Soft symbol pair present |
| in_ready | output | 1 | Decoder can take a symbol |
| in_soft_i | input | 4 | Soft value, 171 branch |
| in_soft_q | input | 4 | Soft value, 133 branch |
| in_erase_i | input | 1 | I value erased |
| in_erase_q | input | 1 | Q value erased |
| diff_en | input | 1 | Enable differential output |
| out_valid | output | 1 | One-cycle strobe for a decoded bit |
| out_bit | output | 1 | Decoded (optionally differential) bit |

## Verification
The assertions assume the upstream source never withdraws or alters a symbol while `in_valid` is high and `in_ready` is low. They also assume `diff_en` changes only while the decoder is idle. The metric-range properties hold for every 4-bit input, because a branch cost can never exceed 30. The stimulus respects these limits: it holds each symbol steady until the handshake completes, inserts random idle gaps, and switches `diff_en` only between symbols after `in_ready` has returned.

// File: rtl/vit_pkg.sv
package vit_pkg;
  // Trellis geometry of the fixed K=7 code
  localparam int K_LEN = 7;
  localparam int ST_W  = K_LEN - 1;
  localparam int NST   = 1 << ST_W;

  // Generators; bit 6 multiplies the newest input bit
  localparam logic [K_LEN-1:0] GEN_I = 7'o171;
  localparam logic [K_LEN-1:0] GEN_Q = 7'o133;

  typedef logic [ST_W-1:0] state_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BEST  = 2'd1,
    PH_TRACE = 2'd2
  } phase_e;

  // Coded pair {I, Q} for a window {next_state, dropped_bit}
  function automatic logic [1:0] code_pair(input logic [K_LEN-1:0] win);
    return {^(win & GEN_I), ^(win & GEN_Q)};
  endfunction
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu #(
  parameter int SOFT_W = 4,
  localparam int BM_W = SOFT_W + 1
) (
  input  logic [SOFT_W-1:0]      soft_i,
  input  logic [SOFT_W-1:0]      soft_q,
  input  logic                   era_i,
  input  logic                   era_q,
  output logic [3:0][BM_W-1:0]   bm
);
  // Distance of one soft value from an expected bit; erased costs nothing
  function automatic logic [SOFT_W-1:0] branch_cost(
    input logic [SOFT_W-1:0] v, input logic b, input logic er);
    if (er) return '0;
    return b ? ~v : v;
  endfunction

  for (genvar c = 0; c < 4; c++) begin : g_bm
    localparam logic [1:0] PAT = 2'(c);
    always_comb
      bm[c] = BM_W'(branch_cost(soft_i, PAT[1], era_i))
            + BM_W'(branch_cost(soft_q, PAT[0], era_q));
  end
endmodule

// File: rtl/vit_acs_unit.sv
module vit_acs_unit
  import vit_pkg::*;
#(
  parameter int PM_W = 10,
  parameter int BM_W = 5,
  parameter int NS_IDX = 0
) (
  input  logic [PM_W-1:0]      pm_even,
  input  logic [PM_W-1:0]      pm_odd,
  input  logic [3:0][BM_W-1:0] bm,
  input  logic [PM_W-1:0]      norm_sub,
  output logic [PM_W-1:0]      pm_new,
  output logic                 dec
);
  localparam state_t     NS = state_t'(NS_IDX);
  localparam logic [1:0] C_EVEN = code_pair({NS, 1'b0});
  localparam logic [1:0] C_ODD  = code_pair({NS, 1'b1});

  logic [PM_W-1:0] cand_even, cand_odd;

  always_comb begin
    cand_even = pm_even + PM_W'(bm[C_EVEN]);
    cand_odd  = pm_odd  + PM_W'(bm[C_ODD]);
    dec       = cand_odd < cand_even;         // tie keeps the even predecessor
    pm_new    = (dec ? cand_odd : cand_even) - norm_sub;
  end
endmodule

// File: rtl/vit_acs_array.sv
module vit_acs_array
  import vit_pkg::*;
#(
  parameter int PM_W = 10,
  parameter int BM_W = 5
) (
  input  logic [NST-1:0][PM_W-1:0] pm_old,
  input  logic [3:0][BM_W-1:0]     bm,
  input  logic [PM_W-1:0]          norm_sub,
  output logic [NST-1:0][PM_W-1:0] pm_new,
  output logic [NST-1:0]           dec_word
);
  for (genvar s = 0; s < NST; s++) begin : g_acs
    localparam int PE = (2 * s) % NST;        // predecessor {s[4:0], 0}
    vit_acs_unit #(.PM_W(PM_W), .BM_W(BM_W), .NS_IDX(s)) u_acs (
      .pm_even (pm_old[PE]),
      .pm_odd  (pm_old[PE+1]),
      .bm      (bm),
      .norm_sub(norm_sub),
      .pm_new  (pm_new[s]),
      .dec     (dec_word[s])
    );
  end
endmodule

// File: rtl/vit_min_tree.sv
module vit_min_tree #(
  parameter int N = 64,
  parameter int W = 10,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] vals,
  output logic [W-1:0]        min_val,
  output logic [IW-1:0]       min_idx
);
  // Pairwise tree; the left (lower index) side wins ties at every level
  always_comb begin
    logic [W-1:0]  v  [N];
    logic [IW-1:0] ix [N];
    for (int i = 0; i < N; i++) begin
      v[i]  = vals[i];
      ix[i] = IW'(i);
    end
    for (int l = 1; l <= IW; l++) begin
      for (int i = 0; i < (N >> l); i++) begin
        if (v[2*i+1] < v[2*i]) begin
          v[i]  = v[2*i+1];
          ix[i] = ix[2*i+1];
        end else begin
          v[i]  = v[2*i];
          ix[i] = ix[2*i];
        end
      end
    end
    min_val = v[0];
    min_idx = ix[0];
  end
endmodule

// File: rtl/vit_survivor.sv
module vit_survivor #(
  parameter int NST = 64,
  parameter int DEPTH = 144,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [NST-1:0] wr_word,
  input  logic [AW-1:0]  rd_addr,
  output logic [NST-1:0] rd_word
);
  logic [NST-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_word;

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/viterbi_k7_decoder.sv
module viterbi_k7_decoder
  import vit_pkg::*;
#(
  parameter int SOFT_W = 4,
  parameter int PM_W   = 10,
  parameter int DEPTH  = 144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SOFT_W-1:0] in_soft_i,
  input  logic [SOFT_W-1:0] in_soft_q,
  input  logic              in_erase_i,
  input  logic              in_erase_q,
  input  logic              diff_en,
  output logic              out_valid,
  output logic              out_bit
);
  localparam int BM_W = SOFT_W + 1;
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 2);
  localparam logic [PM_W-1:0] THRESH    = PM_W'(1) << (PM_W - 3);
  localparam logic [PM_W-1:0] INIT_PM   = THRESH - PM_W'(1);
  localparam logic [AW-1:0]   LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0]   CNT_FULL  = CW'(DEPTH + 1);

  phase_e                   phase;
  logic [NST-1:0][PM_W-1:0] pm_q, pm_acs;
  logic [3:0][BM_W-1:0]     bm;
  logic [NST-1:0]           dec_word, rd_word;
  logic [PM_W-1:0]          pm_min_w, norm_sub;
  state_t                   best_idx, tb_state, tb_next;
  logic [AW-1:0]            wr_ptr, last_ptr, rd_ptr, step_cnt;
  logic [CW-1:0]            sym_cnt;
  logic                     prev_raw, raw_bit;

  // Named internal events, also watched by the bound checker
  logic acc_evt, norm_evt, trace_last, pm_top_any;

  assign in_ready   = (phase == PH_IDLE);
  assign acc_evt    = in_valid && in_ready;
  assign norm_evt   = acc_evt && (pm_min_w >= THRESH);
  assign norm_sub   = (pm_min_w >= THRESH) ? THRESH : '0;
  assign trace_last = (phase == PH_TRACE) && (step_cnt == LAST_ADDR);
  assign tb_next    = {tb_state[ST_W-2:0], rd_word[tb_state]};
  assign raw_bit    = tb_next[ST_W-1];

  always_comb begin
    pm_top_any = 1'b0;
    for (int s = 0; s < NST; s++) pm_top_any = pm_top_any | pm_q[s][PM_W-1];
  end

  vit_bmu #(.SOFT_W(SOFT_W)) u_bmu (
    .soft_i(in_soft_i), .soft_q(in_soft_q),
    .era_i (in_erase_i), .era_q(in_erase_q),
    .bm    (bm)
  );

  vit_acs_array #(.PM_W(PM_W), .BM_W(BM_W)) u_acs_array (
    .pm_old(pm_q), .bm(bm), .norm_sub(norm_sub),
    .pm_new(pm_acs), .dec_word(dec_word)
  );

  // One tree serves both the normalisation test and the traceback start
  vit_min_tree #(.N(NST), .W(PM_W)) u_min (
    .vals(pm_q), .min_val(pm_min_w), .min_idx(best_idx)
  );

  vit_survivor #(.NST(NST), .DEPTH(DEPTH)) u_surv (
    .clk    (clk),
    .wr_en  (acc_evt),
    .wr_addr(wr_ptr),
    .wr_word(dec_word),
    .rd_addr(rd_ptr),
    .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      for (int s = 0; s < NST; s++) pm_q[s] <= (s == 0) ? '0 : INIT_PM;
      wr_ptr    <= '0;
      last_ptr  <= '0;
      rd_ptr    <= '0;
      step_cnt  <= '0;
      sym_cnt   <= '0;
      tb_state  <= '0;
      prev_raw  <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (acc_evt) begin
            pm_q     <= pm_acs;
            last_ptr <= wr_ptr;
            wr_ptr   <= (wr_ptr == LAST_ADDR) ? '0 : wr_ptr + AW'(1);
            if (sym_cnt != CNT_FULL) sym_cnt <= sym_cnt + CW'(1);
            phase    <= PH_BEST;
          end
        end
        PH_BEST: begin
          tb_state <= best_idx;
          rd_ptr   <= last_ptr;
          step_cnt <= '0;
          phase    <= (sym_cnt == CNT_FULL) ? PH_TRACE : PH_IDLE;
        end
        PH_TRACE: begin
          tb_state <= tb_next;
          rd_ptr   <= (rd_ptr == '0) ? LAST_ADDR : rd_ptr - AW'(1);
          step_cnt <= step_cnt + AW'(1);
          if (trace_last) begin
            out_valid <= 1'b1;
            out_bit   <= diff_en ? (raw_bit ^ prev_raw) : raw_bit;
            prev_raw  <= raw_bit;
            phase     <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vit_checker.sv
module vit_checker #(
  parameter int PM_W = 10,
  parameter int BM_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            out_valid,
  input logic            acc_evt,
  input logic            norm_evt,
  input logic            pm_top_any,
  input logic [PM_W-1:0] pm_min_w
);
  localparam logic [PM_W-1:0] THRESH  = PM_W'(1) << (PM_W - 3);
  localparam logic [PM_W:0]   MIN_CAP = {1'b0, THRESH} + (PM_W+1)'(1 << BM_W);

  // R2: taking a symbol makes the decoder busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> !in_ready);

  // R7: output strobe lasts one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: an output only appears at the end of a busy period
  a_r7_out_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready));

  // R6: stored metrics keep their top bit clear
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_top_any);

  // R6: smallest metric stays below threshold plus one branch step
  a_r6_min_capped: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pm_min_w} < MIN_CAP);

  // R6: a normalising update brings the smallest metric under threshold
  a_r6_norm_pulls_down: assert property (@(posedge clk) disable iff (!rst_n)
    norm_evt |=> pm_min_w < THRESH);
endmodule

bind viterbi_k7_decoder vit_checker #(.PM_W(PM_W), .BM_W(BM_W)) u_vit_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .acc_evt   (acc_evt),
  .norm_evt  (norm_evt),
  .pm_top_any(pm_top_any),
  .pm_min_w  (pm_min_w)
);

// File: tb/viterbi_k7_decoder_bench.sv
module viterbi_k7_decoder_bench;
  timeunit 1ns; timeprecision 1ps;

  localparam int D = 144;
  localparam int N1 = 300, N2 = 150, N3 = 120, N4 = 80, N5 = 30;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, diff_en = 1'b0;
  logic [3:0] si = '0, sq = '0;
  logic ei = 1'b0, eq = 1'b0;
  logic in_ready, out_valid, out_bit;

  viterbi_k7_decoder u_viterbi_k7_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_soft_i(si), .in_soft_q(sq), .in_erase_i(ei), .in_erase_q(eq),
    .diff_en(diff_en), .out_valid(out_valid), .out_bit(out_bit)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R3";

  // Behavioural reference: integer metrics, no normalisation
  int          mpm [64];
  logic [63:0] mhist [$];
  int          msyms = 0;
  bit          mprev = 1'b0;
  typedef struct { bit b; int due; } exp_t;
  exp_t        expq [$];
  exp_t        cur_e;
  bit          srcbits [$];
  int          n_out = 0;
  logic [5:0]  enc = '0;

  function automatic void check(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endfunction

  function automatic int cst(logic [3:0] v, bit b, bit er);
    if (er) return 0;
    return b ? 15 - int'(v) : int'(v);
  endfunction

  function automatic void model_step(logic [3:0] a, logic [3:0] b, bit xa, bit xb,
                                     int acc, bit dif);
    int npm [64];
    logic [63:0] dw;
    int best, st, raw;
    dw = '0;
    for (int s = 0; s < 64; s++) npm[s] = 32'h7fffffff;
    for (int p = 0; p < 64; p++) begin
      for (int u = 0; u < 2; u++) begin
        int ns, m;
        logic [6:0] win;
        ns  = (u << 5) | (p >> 1);
        win = 7'((u << 6) | p);
        m   = mpm[p] + cst(a, ^(win & 7'o171), xa) + cst(b, ^(win & 7'o133), xb);
        if (m < npm[ns]) begin
          npm[ns] = m;
          dw[ns]  = p[0];
        end
      end
    end
    for (int s = 0; s < 64; s++) mpm[s] = npm[s];
    mhist.push_back(dw);
    if (mhist.size() > D) void'(mhist.pop_front());
    msyms++;
    if (msyms > D) begin
      best = 0;
      for (int s = 1; s < 64; s++) if (mpm[s] < mpm[best]) best = s;
      st = best;
      for (int j = 0; j < D; j++) begin
        logic [63:0] w;
        w  = mhist[mhist.size() - 1 - j];
        st = ((st << 1) & 63) | int'(w[st]);
      end
      raw = (st >> 5) & 1;
      expq.push_back('{bit'(dif ? (raw ^ int'(mprev)) : raw), acc + D + 1});
      mprev = bit'(raw);
    end
  endfunction

  // Called at a falling edge; returns at a falling edge
  task automatic send(logic [3:0] a, logic [3:0] b, bit xa, bit xb);
    int acc;
    si = a; sq = b; ei = xa; eq = xb; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    acc = cyc + 1;
    model_step(a, b, xa, xb, acc, diff_en);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2", "in_ready after accept", int'(in_ready), 0);
    if ($urandom_range(0, 7) == 0) @(negedge clk);
  endtask

  task automatic send_coded(bit u, int noise_max, int era_pct);
    logic [6:0] win;
    bit ca, cb;
    int na, nb;
    win = {u, enc};
    ca  = ^(win & 7'o171);
    cb  = ^(win & 7'o133);
    enc = {u, enc[5:1]};
    na  = $urandom_range(0, noise_max);
    nb  = $urandom_range(0, noise_max);
    send(4'(ca ? 15 - na : na), 4'(cb ? 15 - nb : nb),
         ($urandom_range(0, 99) < era_pct), ($urandom_range(0, 99) < era_pct));
  endtask

  // Compare outputs against the reference on every clock
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R7", "unexpected out_valid", 1, 0);
      end else begin
        cur_e = expq.pop_front();
        check(out_bit == cur_e.b, cur_req, "decoded bit vs reference", int'(out_bit), int'(cur_e.b));
        check(cyc == cur_e.due, "R7", "output edge", cyc, cur_e.due);
        if (n_out < N1 - D)
          check(out_bit == srcbits[n_out], "R3", "noiseless bit vs source", int'(out_bit), int'(srcbits[n_out]));
        n_out++;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R7 watchdog expired: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    mpm[0] = 0;
    for (int s = 1; s < 64; s++) mpm[s] = 127;   // R1 start values
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // Noiseless stream from state 0 (R3, R1)
    cur_req = "R3";
    for (int i = 0; i < N1; i++) begin
      bit u;
      u = bit'($urandom_range(0, 1));
      srcbits.push_back(u);
      send_coded(u, 0, 0);
      if (i == D - 1)
        check(n_out == 0, "R7", "outputs before depth reached", n_out, 0);
    end

    // Noisy with erasures (R4)
    cur_req = "R4";
    for (int i = 0; i < N2; i++) send_coded(bit'($urandom_range(0, 1)), 10, 20);

    // Heavy noise, metrics climb past threshold repeatedly (R6)
    cur_req = "R6";
    for (int i = 0; i < N3; i++) send_coded(bit'($urandom_range(0, 1)), 12, 0);

    // Differential output (R8), switched while idle
    while (!in_ready) @(negedge clk);
    diff_en = 1'b1;
    cur_req = "R8";
    for (int i = 0; i < N4; i++) send_coded(bit'($urandom_range(0, 1)), 8, 10);

    // Fully erased symbols: every comparison ties (R5)
    cur_req = "R5";
    for (int i = 0; i < N5; i++) send(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), 1'b1, 1'b1);

    for (int w = 0; w < 2 * D + 8 && expq.size() != 0; w++) @(negedge clk);
    check(expq.size() == 0, "R7", "pending outputs at end", expq.size(), 0);
    check(n_out == N1 + N2 + N3 + N4 + N5 - D, "R2", "total outputs", n_out, N1 + N2 + N3 + N4 + N5 - D);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule